// File: doc/BRIEF.md
# Banked Flash Query Read Formatter

This block builds the read word for a flash bank made of several identical narrow devices placed side by side on one data bus. The command decoder elsewhere selects the read mode. This block then turns a byte address and the configured widths into the word the bus sees. The modes are plain array data, the status byte, identification codes, and the characteristic (query) table.

Widths are given as log2 codes: 0 means 1 byte, 1 means 2 bytes and 2 means 4 bytes. Four widths are supplied this way: the access, the bank, each device as wired, and each device at its widest. In the identification and query modes, the block scales the address down to a per-device table index. It forms one device's answer and copies that answer into every device lane of the bank. When an access is wider than the bank, it packs several bank-wide answers side by side. The query table is computed inside the block from parameters. A read strobe loads the result into an output register, and the result appears one cycle later with a valid flag.

Top module: `bflash_rd_fmt`

## Requirements
- R1: While reset is held, and until the first read, `rvalid` is 0 and `rdata` is 0.
- R2: A read strobe sampled on a rising edge gives `rvalid`=1 and the new `rdata` after that edge. A cycle without a strobe gives `rvalid`=0 and leaves `rdata` unchanged.
- R3: Mode code 00 is array read, where byte k of `arr_data` is the stored byte at address+k. A 1-byte access returns byte 0. For 2- and 4-byte accesses, `big_end`=0 puts byte 0 in the least significant position, and `big_end`=1 puts it in the most significant position.
- R4: Mode code 01 is status read. The status byte appears at every byte position that is a multiple of the device width and lies below the access width. All other bytes are 0.
- R5: Mode code 11 is query read. The table index is the address shifted right by `bank_lg` + `max_lg` − `dev_lg`.
- R6: The query table has 82 entries, and any index of 82 or more reads 0. Entries 0x10..0x12 hold 0x51 0x52 0x59, 0x13 holds 0x01, 0x15 holds 0x31, 0x27 holds the device-size parameter, and 0x2C holds 0x01. Entries 0x31..0x33 hold 0x50 0x52 0x49. Entry 0x2A holds 0x08 for a 1-byte bank and 0x0B otherwise.
- R7: Suppose a device is wired narrower than its widest mode. With a 1-byte device width, the table byte fills the device. With any other narrower width, the query answer is 0.
- R8: A device answer narrower than the bank is copied into every device-width slot of the bank. With device width equal to widest width, a query answer is the table byte in the slot's low byte and 0 above it.
- R9: Mode code 10 is identification read. Index bits [7:0] equal to 0 give the manufacturer code, 1 gives the device code, and any other value gives 0. Upper index bits are ignored. The code is cut to the device width.
- R10: When the access is wider than the bank, bank-wide chunk k is answered for address + k × bank width and placed at byte k × bank width.
- R11: In every mode, bytes at or above the access width read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_en | input | 1 | Read strobe |
| mode | input | 2 | Read mode code (00 array, 01 status, 10 ident, 11 query) |
| addr | input | ADDR_W | Byte address of the access |
| acc_lg | input | LGW | log2 of access width in bytes |
| bank_lg | input | LGW | log2 of bank width in bytes |
| dev_lg | input | LGW | log2 of device width as wired |
| max_lg | input | LGW | log2 of device widest width |
| big_end | input | 1 | Array byte order strap |
| status | input | 8 | Current status byte |
| arr_data | input | 8*DATA_BYTES | Stored bytes starting at the address |
| rdata | output | 8*DATA_BYTES | Registered read word |
| rvalid | output | 1 | Read word valid |

## Verification
Packing of several bank-wide chunks and per-device copying inside each chunk happen in the same read. An identification read that is 4 bytes wide on a 2-byte bank of byte-wide devices triggers both, so two different codes each appear twice. The bench judges the exact word 0x18188989. Only that word shows that the chunk order and the copying within each chunk are both correct. Query reads of byte-mode wide parts on a 4-byte bank combine the address scaling with the repetition in the same way.

// File: rtl/bfq_pkg.sv
package bfq_pkg;
  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'b00,
    MODE_STATUS = 2'b01,
    MODE_IDENT  = 2'b10,
    MODE_QUERY  = 2'b11
  } rd_mode_e;
endpackage

// File: rtl/bfq_char_rom.sv
module bfq_char_rom #(
  parameter int         ADDR_W      = 16,
  parameter int         DEPTH       = 82,
  parameter logic [7:0] DEV_SIZE_LG = 8'h17
) (
  input  logic [ADDR_W-1:0] idx,
  input  logic              narrow_bank,
  output logic [7:0]        entry
);
  // characteristic table, computed; out-of-range index reads zero (R6)
  always_comb begin
    entry = 8'h00;
    if (idx < ADDR_W'(DEPTH)) begin
      case (idx[6:0])
        7'h10: entry = 8'h51;
        7'h11: entry = 8'h52;
        7'h12: entry = 8'h59;
        7'h13: entry = 8'h01;
        7'h15: entry = 8'h31;
        7'h27: entry = DEV_SIZE_LG;
        7'h2A: entry = narrow_bank ? 8'h08 : 8'h0B;
        7'h2C: entry = 8'h01;
        7'h31: entry = 8'h50;
        7'h32: entry = 8'h52;
        7'h33: entry = 8'h49;
        7'h3F: entry = 8'h01;
        default: entry = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/bfq_lane.sv
module bfq_lane #(
  parameter int          DATA_BYTES  = 4,
  parameter int          ADDR_W      = 16,
  parameter int          LGW         = 2,
  parameter int          DEPTH       = 82,
  parameter logic [15:0] MFR_CODE    = 16'h0089,
  parameter logic [15:0] DEV_CODE    = 16'h0018,
  parameter logic [7:0]  DEV_SIZE_LG = 8'h17
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LGW-1:0]          bank_lg,
  input  logic [LGW-1:0]          dev_lg,
  input  logic [LGW-1:0]          max_lg,
  input  logic                    is_query,
  output logic [8*DATA_BYTES-1:0] resp
);
  localparam int DW = 8 * DATA_BYTES;

  logic [LGW:0]        shamt;
  logic [ADDR_W-1:0]   idx;
  logic [7:0]          tbl_byte;
  logic [15:0]         id_code;
  logic [DW-1:0]       dev_word;

  // R5: per-device index scaling
  always_comb begin
    shamt = {1'b0, bank_lg} + {1'b0, max_lg} - {1'b0, dev_lg};
    idx   = addr >> shamt;
  end

  bfq_char_rom #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .DEV_SIZE_LG(DEV_SIZE_LG)
  ) u_rom (
    .idx(idx), .narrow_bank(bank_lg == '0), .entry(tbl_byte)
  );

  // R9: only the low index byte selects the code
  always_comb begin
    if (idx[7:0] == 8'd0)      id_code = MFR_CODE;
    else if (idx[7:0] == 8'd1) id_code = DEV_CODE;
    else                       id_code = 16'h0000;
  end

  // one device's answer (R7)
  always_comb begin
    dev_word = '0;
    for (int j = 0; j < DATA_BYTES; j++) begin
      if (is_query) begin
        if (dev_lg == max_lg)
          dev_word[8*j +: 8] = (j == 0) ? tbl_byte : 8'h00;
        else if (dev_lg == '0 && j < (1 << max_lg))
          dev_word[8*j +: 8] = tbl_byte;
      end else if (j < 2) begin
        dev_word[8*j +: 8] = id_code[8*j +: 8];
      end
    end
  end

  // R8: copy the device slot across the bank
  always_comb begin
    resp = '0;
    for (int b = 0; b < DATA_BYTES; b++) begin
      if (b < (1 << bank_lg))
        resp[8*b +: 8] = dev_word[8*(b & ((1 << dev_lg) - 1)) +: 8];
    end
  end
endmodule

// File: rtl/bflash_rd_fmt.sv
module bflash_rd_fmt #(
  parameter int          DATA_BYTES  = 4,
  parameter int          ADDR_W      = 16,
  parameter int          DEPTH       = 82,
  parameter logic [15:0] MFR_CODE    = 16'h0089,
  parameter logic [15:0] DEV_CODE    = 16'h0018,
  parameter logic [7:0]  DEV_SIZE_LG = 8'h17,
  localparam int         LG_MAX      = $clog2(DATA_BYTES),
  localparam int         LGW         = $clog2(LG_MAX + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_en,
  input  logic [1:0]              mode,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LGW-1:0]          acc_lg,
  input  logic [LGW-1:0]          bank_lg,
  input  logic [LGW-1:0]          dev_lg,
  input  logic [LGW-1:0]          max_lg,
  input  logic                    big_end,
  input  logic [7:0]              status,
  input  logic [8*DATA_BYTES-1:0] arr_data,
  output logic [8*DATA_BYTES-1:0] rdata,
  output logic                    rvalid
);
  import bfq_pkg::*;
  localparam int DW = 8 * DATA_BYTES;

  logic [1:0]    rst_sync;
  logic          arst_n;
  rd_mode_e      mode_e;
  logic [DW-1:0] lane_resp [DATA_BYTES];
  logic [DW-1:0] fmt_word;
  logic [DW-1:0] rdata_d, rdata_q;
  logic          rvalid_d, rvalid_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign arst_n = rst_sync[1];

  assign mode_e = rd_mode_e'(mode);

  // R10: one lane per bank-wide chunk
  for (genvar k = 0; k < DATA_BYTES; k++) begin : g_chunk
    logic [ADDR_W-1:0] chunk_addr;
    assign chunk_addr = addr + (ADDR_W'(k) << bank_lg);
    bfq_lane #(
      .DATA_BYTES(DATA_BYTES), .ADDR_W(ADDR_W), .LGW(LGW), .DEPTH(DEPTH),
      .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE), .DEV_SIZE_LG(DEV_SIZE_LG)
    ) u_lane (
      .addr(chunk_addr), .bank_lg(bank_lg), .dev_lg(dev_lg),
      .max_lg(max_lg), .is_query(mode_e == MODE_QUERY),
      .resp(lane_resp[k])
    );
  end

  always_comb begin
    fmt_word = '0;
    for (int b = 0; b < DATA_BYTES; b++) begin
      if (b < (1 << acc_lg)) begin
        unique case (mode_e)
          MODE_ARRAY: begin
            if (big_end)
              fmt_word[8*b +: 8] = arr_data[8*((1 << acc_lg) - 1 - b) +: 8];
            else
              fmt_word[8*b +: 8] = arr_data[8*b +: 8];
          end
          MODE_STATUS: begin
            if ((b & ((1 << dev_lg) - 1)) == 0)
              fmt_word[8*b +: 8] = status;
          end
          default: begin
            fmt_word[8*b +: 8] =
              lane_resp[b >> bank_lg][8*(b & ((1 << bank_lg) - 1)) +: 8];
          end
        endcase
      end
    end
  end

  // next state
  always_comb begin
    rvalid_d = rd_en;
    rdata_d  = rd_en ? fmt_word : rdata_q;
  end

  // registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rvalid_d;
      rdata_q  <= rdata_d;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  a_r2_valid_after_strobe: assert property (@(posedge clk) disable iff (!arst_n)
    rd_en |=> rvalid);
  a_r2_no_valid_idle: assert property (@(posedge clk) disable iff (!arst_n)
    !rd_en |=> !rvalid);
  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!arst_n)
    !rd_en |=> $stable(rdata));
  a_r4_status_every_byte: assert property (@(posedge clk) disable iff (!arst_n)
    (rd_en && mode == 2'b01 && dev_lg == '0 && acc_lg == LGW'(LG_MAX))
      |=> rdata == {DATA_BYTES{$past(status)}});
  if (DATA_BYTES > 1) begin : g_narrow_chk
    a_r11_byte_access_upper_zero: assert property (@(posedge clk) disable iff (!arst_n)
      (rd_en && acc_lg == '0) |=> rdata[DW-1:8] == '0);
  end
endmodule

// File: tb/bflash_rd_fmt_test.sv
`timescale 1ns/1ps
module bflash_rd_fmt_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd_en;
  logic [1:0]  mode;
  logic [15:0] addr;
  logic [1:0]  acc_lg, bank_lg, dev_lg, max_lg;
  logic        big_end;
  logic [7:0]  status;
  logic [31:0] arr_data;
  logic [31:0] rdata;
  logic        rvalid;
  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  bflash_rd_fmt uut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .mode(mode), .addr(addr),
    .acc_lg(acc_lg), .bank_lg(bank_lg), .dev_lg(dev_lg), .max_lg(max_lg),
    .big_end(big_end), .status(status), .arr_data(arr_data),
    .rdata(rdata), .rvalid(rvalid)
  );

  task automatic chk(input logic [32:0] act, input logic [32:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] m, input logic [15:0] a, input logic [1:0] acc,
                    input logic [1:0] bk, input logic [1:0] dv, input logic [1:0] mx,
                    input logic [31:0] exp, input string req);
    @(negedge clk);
    mode = m; addr = a; acc_lg = acc; bank_lg = bk; dev_lg = dv; max_lg = mx;
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk({rvalid, rdata}, {1'b1, exp}, req);
  endtask

  task automatic t_reset;
    chk({rvalid, rdata}, 33'h0, "R1");
  endtask

  task automatic t_array;
    arr_data = 32'h44332211;
    big_end = 1'b0;
    rd(2'b00, 16'h0, 2'd2, 2'd2, 2'd2, 2'd2, 32'h44332211, "R3");
    rd(2'b00, 16'h0, 2'd1, 2'd2, 2'd2, 2'd2, 32'h00002211, "R3");
    rd(2'b00, 16'h0, 2'd0, 2'd2, 2'd2, 2'd2, 32'h00000011, "R3");
    big_end = 1'b1;
    rd(2'b00, 16'h0, 2'd2, 2'd2, 2'd2, 2'd2, 32'h11223344, "R3");
    rd(2'b00, 16'h0, 2'd1, 2'd2, 2'd2, 2'd2, 32'h00001122, "R3");
    rd(2'b00, 16'h0, 2'd0, 2'd2, 2'd2, 2'd2, 32'h00000011, "R3");
    big_end = 1'b0;
  endtask

  task automatic t_status;
    status = 8'h80;
    rd(2'b01, 16'h0, 2'd2, 2'd2, 2'd0, 2'd0, 32'h80808080, "R4");
    rd(2'b01, 16'h0, 2'd2, 2'd2, 2'd1, 2'd1, 32'h00800080, "R4");
    rd(2'b01, 16'h0, 2'd0, 2'd2, 2'd1, 2'd1, 32'h00000080, "R4");
    rd(2'b01, 16'h0, 2'd2, 2'd2, 2'd2, 2'd2, 32'h00000080, "R4");
    rd(2'b01, 16'h0, 2'd1, 2'd2, 2'd0, 2'd0, 32'h00008080, "R11");
  endtask

  task automatic t_query;
    rd(2'b11, 16'h0010, 2'd0, 2'd0, 2'd0, 2'd0, 32'h00000051, "R6");
    rd(2'b11, 16'h002A, 2'd0, 2'd0, 2'd0, 2'd0, 32'h00000008, "R6");
    rd(2'b11, 16'h0027, 2'd0, 2'd0, 2'd0, 2'd0, 32'h00000017, "R6");
    rd(2'b11, 16'h0031, 2'd0, 2'd0, 2'd0, 2'd0, 32'h00000050, "R6");
    rd(2'b11, 16'h0033, 2'd0, 2'd0, 2'd0, 2'd0, 32'h00000049, "R6");
    rd(2'b11, 16'h0020, 2'd1, 2'd1, 2'd1, 2'd1, 32'h00000051, "R5");
    rd(2'b11, 16'h0054, 2'd1, 2'd1, 2'd1, 2'd1, 32'h0000000B, "R5");
  endtask

  task automatic t_range;
    rd(2'b11, 16'h0052, 2'd0, 2'd0, 2'd0, 2'd0, 32'h00000000, "R6");
    rd(2'b11, 16'h0110, 2'd0, 2'd0, 2'd0, 2'd0, 32'h00000000, "R6");
  endtask

  task automatic t_replicate;
    rd(2'b11, 16'h0044, 2'd2, 2'd2, 2'd1, 2'd1, 32'h00520052, "R8");
    rd(2'b11, 16'h0040, 2'd2, 2'd2, 2'd1, 2'd1, 32'h00510051, "R8");
  endtask

  task automatic t_byte_mode;
    rd(2'b11, 16'h0040, 2'd1, 2'd1, 2'd0, 2'd1, 32'h00005151, "R7");
    rd(2'b11, 16'h0088, 2'd2, 2'd2, 2'd0, 2'd1, 32'h52525252, "R7");
    rd(2'b11, 16'h0080, 2'd2, 2'd2, 2'd1, 2'd2, 32'h00000000, "R7");
  endtask

  task automatic t_ident;
    rd(2'b10, 16'h0000, 2'd1, 2'd1, 2'd0, 2'd0, 32'h00008989, "R9");
    rd(2'b10, 16'h0002, 2'd1, 2'd1, 2'd0, 2'd0, 32'h00001818, "R9");
    rd(2'b10, 16'h0202, 2'd1, 2'd1, 2'd0, 2'd0, 32'h00001818, "R9");
    rd(2'b10, 16'h0204, 2'd1, 2'd1, 2'd0, 2'd0, 32'h00000000, "R9");
    rd(2'b10, 16'h0000, 2'd1, 2'd1, 2'd1, 2'd1, 32'h00000089, "R9");
  endtask

  task automatic t_pack;
    rd(2'b11, 16'h0010, 2'd2, 2'd0, 2'd0, 2'd0, 32'h01595251, "R10");
    rd(2'b10, 16'h0000, 2'd2, 2'd1, 2'd1, 2'd1, 32'h00180089, "R10");
    rd(2'b10, 16'h0000, 2'd2, 2'd1, 2'd0, 2'd0, 32'h18188989, "R10");
  endtask

  task automatic t_narrow;
    rd(2'b11, 16'h0040, 2'd0, 2'd2, 2'd0, 2'd0, 32'h00000051, "R11");
    rd(2'b10, 16'h0000, 2'd0, 2'd1, 2'd1, 2'd1, 32'h00000089, "R11");
  endtask

  task automatic t_hold;
    rd(2'b11, 16'h0011, 2'd0, 2'd0, 2'd0, 2'd0, 32'h00000052, "R2");
    @(negedge clk);
    mode = 2'b00; arr_data = 32'hDEADBEEF; addr = 16'h0;
    @(negedge clk);
    chk({rvalid, rdata}, {1'b0, 32'h00000052}, "R2");
    arr_data = 32'h44332211;
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rd_en = 1'b0; mode = 2'b00; addr = '0;
    acc_lg = '0; bank_lg = '0; dev_lg = '0; max_lg = '0;
    big_end = 1'b0; status = 8'h00; arr_data = '0;
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_array;
    t_status;
    t_query;
    t_range;
    t_replicate;
    t_byte_mode;
    t_ident;
    t_pack;
    t_narrow;
    t_hold;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule